// File: doc/BRIEF.md
# Per-Core Doorbell Interrupt and Mailbox Registers

This block is the register file one processor core owns for inter-core signalling. It holds a pending-interrupt word, an enable word, eight mailbox words and a single level interrupt line to its core. Software on the local core reaches it through a 32-bit register port with an 8-bit offset. A remote sender, which has already chosen this core as its target, can post pending bits or mailbox words through a second write-only port. Pending bits are posted by writing a one-hot or multi-bit value to a write-only set port, and acknowledged through a write-only clear port.

The interrupt line is a sticky flag. It is not a continuous function of pending AND enable. It rises only when a set event leaves some enabled bit pending. It falls only when a local clear event leaves nothing pending while some enable bit is on. Software that changes the enable word, or clears bits while the enable word is zero, leaves the line where it was.

Top module: `core_doorbell_regs`

## Requirements
- R1: After reset the pending word, the enable word, all eight mailbox words, `irq` and `err` are all zero.
- R2: Offsets are decoded as follows: pending 0x00, enable 0x04, set 0x08, clear 0x0C, mailbox word i at 0x20+4*i for i in 0..7. Any other offset, unaligned ones included, reads as zero and a write to it changes no state.
- R3: `err` is high for exactly one cycle, the cycle after any of these: a local read or write to an undecoded offset, a local write to the pending word, or a remote write to any offset other than set or a mailbox word. Otherwise it is low.
- R4: The pending word is read-only: a local write to 0x00 leaves it unchanged.
- R5: A write to the set port ORs the written value into the pending word.
- R6: `irq` goes high after a set event only when the resulting pending word ANDed with the enable word is nonzero. A set event whose result has no enabled bit leaves `irq` unchanged.
- R7: A local write to the clear port clears the written bits in the pending word. If the pending word becomes zero and the enable word is nonzero, `irq` goes low.
- R8: `irq` changes on nothing else. It holds through enable writes, through clears that leave pending bits, and through clears made while the enable word is zero.
- R9: Reads of the set and clear ports return zero.
- R10: The enable word is written from the local port only and reads back its stored value.
- R11: Each mailbox word is written and read back independently at its own offset.
- R12: The remote port can write only the set port and the mailbox words. A remote write elsewhere is dropped.
- R13: When both ports write in one cycle, set values from both are merged, a local clear is applied after the merge, and `irq` is judged on the final pending word against the enable word held before that edge. When both write the same mailbox word, the local value is kept. When they write different words, both are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_addr | input | 8 | Local register offset |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Read data for `loc_addr`, combinational |
| rmt_wr | input | 1 | Remote write strobe |
| rmt_addr | input | 8 | Remote register offset |
| rmt_wdata | input | 32 | Remote write data |
| irq | output | 1 | Level interrupt to the owning core |
| err | output | 1 | One-cycle pulse for an illegal access |

## Verification
Two cases let the remote and local ports act in the same cycle. In the first, a local clear meets a remote set of the pending word. In the second, both ports write mailbox storage, either the same word or neighbouring words. The bench drives both strobes on the same edge. It then reads the pending word and the mailbox words back and samples `irq`, and it judges each result against the merge-then-clear order and the local-wins rule. It also covers a simultaneous clear and set of disjoint bits, where `irq` must stay high.

// File: rtl/core_doorbell_regs.sv
module core_doorbell_regs #(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int NBOX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_wr,
  input  logic          loc_rd,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          rmt_wr,
  input  logic [AW-1:0] rmt_addr,
  input  logic [DW-1:0] rmt_wdata,
  output logic          irq,
  output logic          err
);
  localparam logic [AW-1:0] OFS_PEND = AW'(8'h00);
  localparam logic [AW-1:0] OFS_EN   = AW'(8'h04);
  localparam logic [AW-1:0] OFS_SET  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8'h0C);
  localparam int            BOX_W0   = 8;
  localparam int            BW       = (NBOX > 1) ? $clog2(NBOX) : 1;

  logic [DW-1:0] pend, en;
  logic [DW-1:0] mbx [NBOX];

  logic [AW-3:0] l_word, r_word;
  assign l_word = loc_addr[AW-1:2];
  assign r_word = rmt_addr[AW-1:2];

  logic l_box, r_box;
  assign l_box = (loc_addr[1:0] == 2'b00) && (int'(l_word) >= BOX_W0) && (int'(l_word) < BOX_W0 + NBOX);
  assign r_box = (rmt_addr[1:0] == 2'b00) && (int'(r_word) >= BOX_W0) && (int'(r_word) < BOX_W0 + NBOX);

  logic [BW-1:0] l_idx, r_idx;
  assign l_idx = BW'(l_word - (AW-2)'(BOX_W0));
  assign r_idx = BW'(r_word - (AW-2)'(BOX_W0));

  logic l_pend, l_en, l_set, l_clr, l_hit, r_set;
  assign l_pend = loc_addr == OFS_PEND;
  assign l_en   = loc_addr == OFS_EN;
  assign l_set  = loc_addr == OFS_SET;
  assign l_clr  = loc_addr == OFS_CLR;
  assign l_hit  = l_pend | l_en | l_set | l_clr | l_box;
  assign r_set  = rmt_addr == OFS_SET;

  logic          set_ev, clr_ev;
  logic [DW-1:0] setv, clrv, pend_n;
  assign set_ev = (loc_wr & l_set) | (rmt_wr & r_set);
  assign clr_ev = loc_wr & l_clr;
  assign setv   = ({DW{loc_wr & l_set}} & loc_wdata) | ({DW{rmt_wr & r_set}} & rmt_wdata);
  assign clrv   = {DW{clr_ev}} & loc_wdata;
  assign pend_n = (pend | setv) & ~clrv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
      err  <= 1'b0;
      for (int i = 0; i < NBOX; i++) mbx[i] <= '0;
    end else begin
      pend <= pend_n;
      if (loc_wr && l_en) en <= loc_wdata;
      if (set_ev && |(pend_n & en)) irq <= 1'b1;
      else if (clr_ev && pend_n == '0 && |en) irq <= 1'b0;
      err <= (loc_rd & ~l_hit) | (loc_wr & (~l_hit | l_pend)) | (rmt_wr & ~(r_set | r_box));
      for (int i = 0; i < NBOX; i++) begin
        if (loc_wr && l_box && l_idx == BW'(i)) mbx[i] <= loc_wdata;
        else if (rmt_wr && r_box && r_idx == BW'(i)) mbx[i] <= rmt_wdata;
      end
    end
  end

  always_comb begin
    loc_rdata = '0;
    if (l_pend)     loc_rdata = pend;
    else if (l_en)  loc_rdata = en;
    else if (l_box) loc_rdata = mbx[l_idx];
  end
endmodule

// File: rtl/core_doorbell_regs_chk.sv
module core_doorbell_regs_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loc_wr,
  input logic          loc_rd,
  input logic [AW-1:0] loc_addr,
  input logic [DW-1:0] loc_rdata,
  input logic          rmt_wr,
  input logic [AW-1:0] rmt_addr,
  input logic          irq,
  input logic          err
);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((loc_wr && loc_addr == AW'(8'h08)) || (rmt_wr && rmt_addr == AW'(8'h08))));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(loc_wr && loc_addr == AW'(8'h0C)));

  // R9
  port_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_addr == AW'(8'h08) || loc_addr == AW'(8'h0C)) |-> loc_rdata == '0);

  // R3
  pend_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_addr == AW'(8'h00)) |=> err);

  // R2
  gap_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rd && loc_addr >= AW'(8'h10) && loc_addr < AW'(8'h20)) |-> loc_rdata == '0);
endmodule

bind core_doorbell_regs core_doorbell_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
  .loc_rdata(loc_rdata), .rmt_wr(rmt_wr), .rmt_addr(rmt_addr), .irq(irq), .err(err)
);

// File: tb/core_doorbell_regs_bench.sv
`timescale 1ns/1ps
module core_doorbell_regs_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        loc_wr = 0, loc_rd = 0, rmt_wr = 0;
  logic [7:0]  loc_addr = 0, rmt_addr = 0;
  logic [31:0] loc_wdata = 0, rmt_wdata = 0, loc_rdata;
  logic        irq, err;

  core_doorbell_regs u_core_doorbell_regs (
    .clk(clk), .rst_n(rst_n), .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .rmt_wr(rmt_wr), .rmt_addr(rmt_addr),
    .rmt_wdata(rmt_wdata), .irq(irq), .err(err)
  );

  typedef struct {int kind; logic [31:0] exp; string req;} item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // kind 0: loc_rdata, 1: irq, 2: err
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? loc_rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, err};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push_exp(int kind, logic [31:0] v, string r);
    item_t it;
    it.kind = kind; it.exp = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1; loc_wr = 1; loc_addr = a; loc_wdata = d;
    @(posedge clk); #1; loc_wr = 0;
  endtask

  task automatic rwr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1; rmt_wr = 1; rmt_addr = a; rmt_wdata = d;
    @(posedge clk); #1; rmt_wr = 0;
  endtask

  task automatic both(logic [7:0] la, logic [31:0] ld, logic [7:0] ra, logic [31:0] rd_);
    @(posedge clk); #1; loc_wr = 1; loc_addr = la; loc_wdata = ld;
    rmt_wr = 1; rmt_addr = ra; rmt_wdata = rd_;
    @(posedge clk); #1; loc_wr = 0; rmt_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string r);
    @(posedge clk); #1; loc_rd = 1; loc_addr = a; push_exp(0, e, r);
    @(posedge clk); #1; loc_rd = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    push_exp(1, 0, "R1"); push_exp(2, 0, "R1");
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h20, 0, "R1"); rd(8'h3C, 0, "R1");

    wr(8'h04, 32'hF0); push_exp(2, 0, "R3");
    rd(8'h04, 32'hF0, "R10");
    wr(8'h08, 32'h03); push_exp(1, 0, "R6");
    rd(8'h00, 32'h03, "R5");
    wr(8'h08, 32'h10); push_exp(1, 1, "R6");
    rd(8'h00, 32'h13, "R5");
    wr(8'h0C, 32'h01); push_exp(1, 1, "R8");
    rd(8'h00, 32'h12, "R7");
    wr(8'h04, 32'h0); push_exp(1, 1, "R8");
    wr(8'h0C, 32'h12); push_exp(1, 1, "R8");
    rd(8'h00, 32'h0, "R7");
    wr(8'h04, 32'hFF); push_exp(1, 1, "R8");
    wr(8'h0C, 32'h0); push_exp(1, 0, "R7");

    wr(8'h00, 32'hFFFF); push_exp(2, 1, "R3");
    rd(8'h00, 32'h0, "R4");
    wr(8'h08, 32'h0); rd(8'h08, 32'h0, "R9"); rd(8'h0C, 32'h0, "R9");

    for (int i = 0; i < 8; i++) wr(8'(8'h20 + 4 * i), 32'hA500_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), 32'hA500_0000 + 32'(i), "R11");

    rd(8'h10, 0, "R2"); push_exp(2, 1, "R3");
    rd(8'h21, 0, "R2"); push_exp(2, 1, "R3");
    wr(8'h40, 32'hDEAD); push_exp(2, 1, "R3");
    @(posedge clk); #1; push_exp(2, 0, "R3");
    rd(8'h40, 0, "R2");
    wr(8'h22, 32'hBEEF); rd(8'h20, 32'hA500_0000, "R2");
    rd(8'h3C, 32'hA500_0007, "R2");

    rwr(8'h08, 32'h4); push_exp(1, 1, "R12"); push_exp(2, 0, "R12");
    rd(8'h00, 32'h4, "R12");
    rwr(8'h24, 32'h1234); rd(8'h24, 32'h1234, "R12");
    rwr(8'h04, 32'h0); push_exp(2, 1, "R12");
    rd(8'h04, 32'hFF, "R12");
    rwr(8'h0C, 32'h4); push_exp(2, 1, "R12"); push_exp(1, 1, "R12");
    rd(8'h00, 32'h4, "R12");

    both(8'h0C, 32'h7, 8'h08, 32'h1); push_exp(1, 0, "R13");
    rd(8'h00, 32'h0, "R13");
    both(8'h08, 32'h2, 8'h08, 32'h8); push_exp(1, 1, "R13");
    rd(8'h00, 32'hA, "R13");
    both(8'h0C, 32'hA, 8'h08, 32'h20); push_exp(1, 1, "R13");
    rd(8'h00, 32'h20, "R13");
    both(8'h28, 32'h1111, 8'h28, 32'h2222); rd(8'h28, 32'h1111, "R13");
    both(8'h2C, 32'h3333, 8'h30, 32'h4444);
    rd(8'h2C, 32'h3333, "R13"); rd(8'h30, 32'h4444, "R13");

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule